// File: doc/BRIEF.md
# Store-and-Forward Packet Line Splitter

This block sits between a segmented packet source and a transmit MAC. That MAC needs its valid signal held high from the first beat of a packet to the last one. Each input line carries several fixed-width segments. Every segment has its own valid, start and end flag, so one line can close one packet and open the next. The block packs the valid segments of every accepted line into a segment buffer, keeping their order. A packet is only released once its last segment is in the buffer, so nothing upstream can make a gap appear in it on the way out.

On the output, every beat carries segments of exactly one packet. A beat's segments always begin at segment 0. The beat ends early at the packet's last segment, so the next packet starts on the following beat. Both sides use valid/ready. An input line is taken on a cycle where `in_valid` and `in_ready` are both high. An output beat is consumed on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the offered beat stays unchanged.

`in_ready` is driven from buffer occupancy alone. It never depends on `in_valid` in the same cycle. `DEPTH` must be a power of two and no smaller than `NSEG`.

Top module: `sf_pkt_splitter`

## Requirements
- R1: From the beat with `out_sop` high until the beat with `out_eop` high has been consumed, `out_valid` stays high on every cycle.
- R2: `out_valid` is high exactly when the buffer holds at least one packet whose end segment has been accepted. The rise comes on the cycle after the line carrying that end segment is taken.
- R3: Each beat carries segments of one packet only. `out_eop` is high on the beat that ends with a packet's last segment, and the next packet begins on a later beat.
- R4: The used segments of a beat start at segment 0 and are contiguous. A beat of n segments has `out_seg_vld` equal to 2^n - 1. `out_sop` is high on a packet's first beat, where segment 0 holds the packet's first segment.
- R5: Input segment i occupies bits [i*SEGW +: SEGW] and its flags are bit i of `in_seg_vld`/`in_seg_sop`/`in_seg_eop`. Segments with a valid bit of 0 are ignored, whatever their data and flags. Valid segments leave in packet order: lower segment index first within a line, earlier line first. Output segment j uses the same bit placement, and unused output segments read as zero.
- R6: While `out_valid` is high and `out_ready` is low, the beat (data, segment mask, start and end flags) holds unchanged into the next cycle.
- R7: `in_ready` is high exactly when at least `NSEG` buffer entries are free. A line offered while it is low is not taken and is not lost.
- R8: `cfg_overflow` is high when `in_ready` is low and the buffer holds no complete packet, meaning a packet longer than the buffer has jammed it. Packets of up to `DEPTH-NSEG+1` segments always pass.
- R9: While `rst_n` is low, `out_valid` and `cfg_overflow` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input line offered |
| in_ready | output | 1 | Room for a full line |
| in_data | input | NSEG*SEGW | Input line, segment i at [i*SEGW +: SEGW] |
| in_seg_vld | input | NSEG | Segment carries packet data |
| in_seg_sop | input | NSEG | Segment is a packet's first |
| in_seg_eop | input | NSEG | Segment is a packet's last |
| out_valid | output | 1 | Output beat offered |
| out_ready | input | 1 | Sink takes the beat |
| out_data | output | NSEG*SEGW | Output beat, packet realigned to segment 0 |
| out_seg_vld | output | NSEG | Used segments of the beat |
| out_sop | output | 1 | Beat starts a packet |
| out_eop | output | 1 | Beat ends a packet |
| cfg_overflow | output | 1 | Buffer jammed by an oversized packet |

## Verification
Every output is combinational from registered state. An accepted line therefore shows in `out_valid` and `in_ready` one cycle later. A consumed beat frees its space, and the next beat appears, one cycle later. The bench drives inputs just after the rising edge and samples at the falling edge. At each falling edge it compares `out_valid` against its own count of complete packets held, and `in_ready` against its own occupancy count. It then updates those counts only for the handshakes that the following rising edge will perform. Each consumed beat is compared with the head of a segment queue built when the stimulus was created. A held beat is compared, one falling edge later, with the copy taken when it was first offered.

// File: rtl/sfpl_pkg.sv
package sfpl_pkg;
  // per-segment marker kept beside the data in the buffer
  typedef struct packed {
    logic sop;
    logic eop;
  } seg_tag_t;
endpackage

// File: rtl/sfpl_line_pack.sv
// Packs the valid segments of one line: buffer offset of each, number written, number of ends.
module sfpl_line_pack #(
  parameter int NSEG = 4,
  parameter int CW   = 3
) (
  input  logic [NSEG-1:0]    seg_vld,
  input  logic [NSEG-1:0]    seg_eop,
  output logic [NSEG*CW-1:0] seg_offs,
  output logic [CW-1:0]      n_wr,
  output logic [CW-1:0]      n_end
);
  always_comb begin
    logic [CW-1:0] acc;
    logic [CW-1:0] ends;
    acc  = '0;
    ends = '0;
    seg_offs = '0;
    for (int i = 0; i < NSEG; i++) begin
      seg_offs[i*CW +: CW] = acc;
      acc  = acc + CW'(seg_vld[i]);
      ends = ends + CW'(seg_vld[i] & seg_eop[i]);
    end
    n_wr  = acc;
    n_end = ends;
  end
endmodule

// File: rtl/sfpl_seg_ram.sv
// Segment buffer: NSEG scattered writes per cycle, NSEG consecutive reads from the head.
module sfpl_seg_ram
  import sfpl_pkg::*;
#(
  parameter int NSEG  = 4,
  parameter int SEGW  = 128,
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int CW    = 3
) (
  input  logic                 clk,
  input  logic [NSEG-1:0]      we,
  input  logic [AW-1:0]        wbase,
  input  logic [NSEG*CW-1:0]   woffs,
  input  logic [NSEG*SEGW-1:0] wdata,
  input  seg_tag_t [NSEG-1:0]  wtag,
  input  logic [AW-1:0]        rbase,
  output logic [NSEG*SEGW-1:0] rdata,
  output logic [NSEG-1:0]      reop,
  output logic                 rsop
);
  logic [SEGW-1:0] mem_d [DEPTH];
  seg_tag_t        mem_t [DEPTH];
  logic [AW-1:0]   waddr [NSEG];

  always_comb begin
    for (int i = 0; i < NSEG; i++) waddr[i] = wbase + AW'(woffs[i*CW +: CW]);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSEG; i++) begin
      if (we[i]) begin
        mem_d[waddr[i]] <= wdata[i*SEGW +: SEGW];
        mem_t[waddr[i]] <= wtag[i];
      end
    end
  end

  for (genvar j = 0; j < NSEG; j++) begin : g_rd
    assign rdata[j*SEGW +: SEGW] = mem_d[rbase + AW'(j)];
    assign reop[j]               = mem_t[rbase + AW'(j)].eop;
  end
  assign rsop = mem_t[rbase].sop;
endmodule

// File: rtl/sfpl_beat_cut.sv
// Decides how many head segments form the next beat: up to the first end, at most NSEG.
module sfpl_beat_cut #(
  parameter int NSEG = 4,
  parameter int UW   = 7,
  parameter int CW   = 3
) (
  input  logic [NSEG-1:0] head_eop,
  input  logic [UW-1:0]   used,
  output logic [CW-1:0]   len,
  output logic [NSEG-1:0] mask,
  output logic            ends
);
  always_comb begin
    logic found;
    found = 1'b0;
    len   = CW'(NSEG);
    for (int j = 0; j < NSEG; j++) begin
      if (!found && (UW'(j) < used) && head_eop[j]) begin
        found = 1'b1;
        len   = CW'(j + 1);
      end
    end
    ends = found;
    for (int j = 0; j < NSEG; j++) mask[j] = CW'(j) < len;
  end
endmodule

// File: rtl/sf_pkt_splitter.sv
module sf_pkt_splitter
  import sfpl_pkg::*;
#(
  parameter int NSEG  = 4,
  parameter int SEGW  = 128,
  parameter int DEPTH = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NSEG*SEGW-1:0] in_data,
  input  logic [NSEG-1:0]      in_seg_vld,
  input  logic [NSEG-1:0]      in_seg_sop,
  input  logic [NSEG-1:0]      in_seg_eop,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [NSEG*SEGW-1:0] out_data,
  output logic [NSEG-1:0]      out_seg_vld,
  output logic                 out_sop,
  output logic                 out_eop,
  output logic                 cfg_overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int CW = $clog2(NSEG + 1);
  localparam int KW = $clog2(DEPTH + 1);

  logic [PW-1:0]        wptr, rptr, used;
  logic [KW-1:0]        pkt_cnt;
  logic [NSEG*CW-1:0]   offs;
  logic [CW-1:0]        n_wr, n_end, beat_len;
  logic [NSEG-1:0]      we, head_eop, beat_mask;
  logic                 head_sop, beat_ends, wr_fire, rd_fire;
  logic [NSEG*SEGW-1:0] head_data;
  seg_tag_t [NSEG-1:0]  wtag;

  assign used     = wptr - rptr;
  assign in_ready = used <= PW'(DEPTH - NSEG);
  assign wr_fire  = in_valid && in_ready;
  assign we       = wr_fire ? in_seg_vld : '0;

  always_comb begin
    for (int i = 0; i < NSEG; i++) wtag[i] = '{sop: in_seg_sop[i], eop: in_seg_eop[i]};
  end

  sfpl_line_pack #(.NSEG(NSEG), .CW(CW)) u_pack (
    .seg_vld(in_seg_vld), .seg_eop(in_seg_eop),
    .seg_offs(offs), .n_wr(n_wr), .n_end(n_end)
  );

  sfpl_seg_ram #(.NSEG(NSEG), .SEGW(SEGW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ram (
    .clk(clk), .we(we), .wbase(wptr[AW-1:0]), .woffs(offs), .wdata(in_data), .wtag(wtag),
    .rbase(rptr[AW-1:0]), .rdata(head_data), .reop(head_eop), .rsop(head_sop)
  );

  sfpl_beat_cut #(.NSEG(NSEG), .UW(PW), .CW(CW)) u_cut (
    .head_eop(head_eop), .used(used), .len(beat_len), .mask(beat_mask), .ends(beat_ends)
  );

  assign out_valid    = pkt_cnt != '0;
  assign rd_fire      = out_valid && out_ready;
  assign out_sop      = out_valid && head_sop;
  assign out_eop      = out_valid && beat_ends;
  assign out_seg_vld  = out_valid ? beat_mask : '0;
  assign cfg_overflow = !in_ready && !out_valid;

  for (genvar j = 0; j < NSEG; j++) begin : g_out
    assign out_data[j*SEGW +: SEGW] = out_seg_vld[j] ? head_data[j*SEGW +: SEGW] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      pkt_cnt <= '0;
    end else begin
      if (wr_fire) wptr <= wptr + PW'(n_wr);
      if (rd_fire) rptr <= rptr + PW'(beat_len);
      pkt_cnt <= pkt_cnt + (wr_fire ? KW'(n_end) : KW'(0))
                         - ((rd_fire && beat_ends) ? KW'(1) : KW'(0));
    end
  end
endmodule

// File: rtl/sfpl_chk.sv
module sfpl_chk #(
  parameter int NSEG = 4,
  parameter int SEGW = 128
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [NSEG*SEGW-1:0] out_data,
  input logic [NSEG-1:0]      out_seg_vld,
  input logic                 out_sop,
  input logic                 out_eop,
  input logic                 cfg_overflow
);
  logic mid;
  always_ff @(posedge clk) begin
    if (!rst_n) mid <= 1'b0;
    else if (out_valid && out_ready) mid <= !out_eop;
  end

  // R1
  mid_pkt_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) mid |-> out_valid);
  // R1
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n) (mid && out_valid) |-> !out_sop);
  // R6
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_seg_vld)
                                   && $stable(out_sop) && $stable(out_eop)));
  // R4
  seg_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_seg_vld[0] && ((out_seg_vld & (out_seg_vld + NSEG'(1))) == '0)));
  // R8
  overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_overflow |-> (!in_ready && !out_valid));
endmodule

bind sf_pkt_splitter sfpl_chk #(.NSEG(NSEG), .SEGW(SEGW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_seg_vld(out_seg_vld), .out_sop(out_sop), .out_eop(out_eop),
  .cfg_overflow(cfg_overflow)
);

// File: tb/sf_pkt_splitter_tb.sv
module sf_pkt_splitter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG  = 4;
  localparam int SEGW  = 16;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic                 in_valid, in_ready, out_valid, out_ready, out_sop, out_eop, cfg_overflow;
  logic [NSEG*SEGW-1:0] in_data, out_data;
  logic [NSEG-1:0]      in_seg_vld, in_seg_sop, in_seg_eop, out_seg_vld;

  sf_pkt_splitter #(.NSEG(NSEG), .SEGW(SEGW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_seg_vld(in_seg_vld), .in_seg_sop(in_seg_sop), .in_seg_eop(in_seg_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_seg_vld(out_seg_vld), .out_sop(out_sop), .out_eop(out_eop), .cfg_overflow(cfg_overflow)
  );

  typedef struct packed {
    logic [SEGW-1:0] d;
    logic            s;
    logic            e;
  } seg_t;

  seg_t src_q[$];
  seg_t exp_q[$];
  int n_chk = 0, n_fail = 0, occ = 0, cpl = 0, line_no = 0, cyc = 0, pkt_id = 0;
  int lane_mode = 0, rdy_mode = 0;
  bit mid = 0, held = 0;
  logic [NSEG*SEGW-1:0] hold_d;
  logic [NSEG-1:0]      hold_m;
  logic                 hold_e;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic add_pkt(input int len);
    for (int i = 0; i < len; i++) begin
      seg_t s;
      s.d = {pkt_id[7:0], 8'(i)};
      s.s = (i == 0);
      s.e = (i == len - 1);
      src_q.push_back(s);
      exp_q.push_back(s);
    end
    pkt_id++;
  endtask

  // idle segments carry junk data and set flags (R5: they must be ignored)
  task automatic load_line();
    int n, base;
    in_valid = 1'b0;
    in_data = {NSEG{16'hDEAD}};
    in_seg_vld = '0;
    in_seg_sop = '1;
    in_seg_eop = '1;
    if (src_q.size() == 0) return;
    if (lane_mode == 1 && (line_no % 5) == 4) begin
      line_no++;
      return;
    end
    n = (lane_mode == 0) ? NSEG : 1 + (line_no % NSEG);
    if (n > src_q.size()) n = src_q.size();
    base = (line_no % 2) ? 0 : NSEG - n;
    for (int k = 0; k < n; k++) begin
      seg_t s;
      s = src_q.pop_front();
      in_data[(base+k)*SEGW +: SEGW] = s.d;
      in_seg_vld[base+k] = 1'b1;
      in_seg_sop[base+k] = s.s;
      in_seg_eop[base+k] = s.e;
    end
    in_valid = 1'b1;
    line_no++;
  endtask

  task automatic step();
    bit acc;
    int k;
    logic [NSEG*SEGW-1:0] expd;
    logic [NSEG-1:0] expm;
    @(negedge clk);
    cyc++;
    chk(out_valid == (cpl > 0), "R2", "out_valid vs complete packets held", out_valid, cpl > 0);
    chk(in_ready == ((DEPTH - occ) >= NSEG), "R7", "in_ready vs free entries", in_ready,
        (DEPTH - occ) >= NSEG);
    if (mid) chk(out_valid, "R1", "valid gap inside packet", out_valid, 1);
    if (held) chk(out_valid && out_data == hold_d && out_seg_vld == hold_m && out_eop == hold_e,
                  "R6", "held beat changed", out_data, hold_d);
    held = 0;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R3", "beat with nothing expected", out_seg_vld, 0);
      end else begin
        k = 0;
        for (int j = 0; j < NSEG && j < exp_q.size(); j++) begin
          k = j + 1;
          if (exp_q[j].e) break;
        end
        expd = '0;
        for (int j = 0; j < k; j++) expd[j*SEGW +: SEGW] = exp_q[j].d;
        expm = NSEG'((1 << k) - 1);
        chk(out_seg_vld == expm, "R4", "segment mask", out_seg_vld, expm);
        chk(out_sop == exp_q[0].s, "R4", "start flag", out_sop, exp_q[0].s);
        chk(out_eop == exp_q[k-1].e, "R3", "end flag", out_eop, exp_q[k-1].e);
        chk(out_data == expd, "R5", "beat data", out_data, expd);
        if (exp_q[k-1].e) cpl--;
        for (int j = 0; j < k; j++) void'(exp_q.pop_front());
        occ -= k;
        mid = !out_eop;
      end
    end else if (out_valid) begin
      held = 1;
      hold_d = out_data;
      hold_m = out_seg_vld;
      hold_e = out_eop;
    end
    acc = in_valid && in_ready;
    if (acc) begin
      occ += $countones(in_seg_vld);
      cpl += $countones(in_seg_vld & in_seg_eop);
    end
    @(posedge clk);
    #1;
    if (acc || !in_valid) load_line();
    out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? cyc[0] : ((cyc % 8) < 2);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    in_valid = 1'b0;
    in_data = '0;
    in_seg_vld = '0;
    in_seg_sop = '0;
    in_seg_eop = '0;
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R9
    chk(!out_valid && in_ready && !cfg_overflow, "R9", "reset state",
        {out_valid, in_ready, cfg_overflow}, 3'b010);
    rst_n = 1'b1;

    // sweep: lane packing x sink pattern x packet lengths (1..9 plus largest guaranteed)
    for (int lm = 0; lm < 2; lm++) begin
      for (int rm = 0; rm < 3; rm++) begin
        lane_mode = lm;
        rdy_mode = rm;
        for (int len = 1; len <= 9; len++) add_pkt(len);
        add_pkt(DEPTH - NSEG + 1);   // R8: largest size that always passes
        add_pkt(3);
        add_pkt(1);
        while (src_q.size() != 0 || exp_q.size() != 0 || in_valid) step();
        repeat (3) step();
      end
    end

    // jam: a packet longer than the buffer
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    in_valid = 1'b1;
    in_data = '0;
    in_seg_vld = '1;
    in_seg_sop = 4'b0001;
    in_seg_eop = '0;
    @(negedge clk);
    chk(!cfg_overflow, "R8", "no flag while space remains", cfg_overflow, 0);
    @(posedge clk);
    #1;
    in_seg_sop = '0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(!in_ready, "R7", "in_ready with full buffer", in_ready, 0);
    chk(cfg_overflow, "R8", "jam flagged", cfg_overflow, 1);
    chk(!out_valid, "R2", "no output without an end segment", out_valid, 0);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    // R9
    chk(!out_valid && in_ready && !cfg_overflow, "R9", "state after second reset",
        {out_valid, in_ready, cfg_overflow}, 3'b010);
    summary();
    $finish;
  end
endmodule